// File: doc/BRIEF.md
# Checkpointed Integer Register File

This block holds the integer architectural state of a core that runs speculative code in large regions and must be able to undo a whole region at once. Each of the 64 registers has a working value that instructions read and write. The first 48 registers also have a backup value. Between checkpoints, execution changes only the working values.

A single `commit_i` pulse takes a new checkpoint: in one cycle it copies every backed-up working register into its backup. A single `rollback_i` pulse discards the speculative region: in one cycle it loads every backed-up working register from its backup. The 16 registers without a backup serve as scratch temporaries, and neither pulse touches them.

Access is through two combinational read ports and one write port. The write port carries a per-byte enable, so an instruction can update part of a register. A read of the register being written in the same cycle returns the merged value. The logic that decides when to commit or roll back lives outside this block.

Top module: `ckrf_top`

## Requirements
- R1: After synchronous reset, every register reads 0, and a rollback issued right after reset also leaves every register at 0, because both copies are cleared.
- R2: `rd0_data` and `rd1_data` combinationally return the working value of the register selected by `rd0_addr` and `rd1_addr`.
- R3: A write with `wr_en`=1 replaces bits [8i+7:8i] of the working register `wr_addr` with the same bits of `wr_data` only where `wr_be[i]`=1. The other lanes keep their value, and `wr_be`=4'b0000 changes nothing.
- R4: On a `commit_i` cycle without rollback, each register 0..47 gets a backup equal to its working value after that cycle's write. A write in the commit cycle is therefore part of the checkpoint.
- R5: On a `rollback_i` cycle, each working register 0..47 takes its backup value, and that value is visible on the next cycle.
- R6: Registers 48..63 have no backup. Commit and rollback leave them unchanged, while ordinary writes still update them.
- R7: When `commit_i` and `rollback_i` are both high, the rollback is performed and the backups keep their previous values.
- R8: A write presented in a `rollback_i` cycle is discarded, whatever its address.
- R9: When a read address equals `wr_addr` during an accepted write, the read port returns the byte-merged value that the register will hold after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 6 | Register written |
| wr_be | input | 4 | Byte-lane enables, bit i covers bits [8i+7:8i] |
| wr_data | input | 32 | Write data |
| commit_i | input | 1 | Checkpoint pulse |
| rollback_i | input | 1 | Restore pulse |
| rd0_addr | input | 6 | Read port 0 address |
| rd0_data | output | 32 | Read port 0 data |
| rd1_addr | input | 6 | Read port 1 address |
| rd1_data | output | 32 | Read port 1 data |

## Verification
The assertions watch read port 0 only, and they assume that every input is a known value in every cycle after reset. They also assume that any pulse combination is legal, including commit and rollback together and a write in either pulse cycle. The stimulus holds read addresses and write requests for one full cycle each, from one falling edge to the next. It draws pulses and byte-enable patterns so that simultaneous pulses, writes in pulse cycles and all-zero enables all occur, and so that reads often target the register being written in that cycle or the one written in the previous cycle.

// File: rtl/ckrf_pkg.sv
package ckrf_pkg;

    parameter int NREGS   = 64;
    parameter int NSHADOW = 48;
    parameter int DW      = 32;

    localparam int AW    = $clog2(NREGS);
    localparam int LANES = DW / 8;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_RESTORE = 2'd2
    } ckpt_op_e;

    typedef struct packed {
        logic             en;
        logic [AW-1:0]    addr;
        logic [LANES-1:0] be;
        logic [DW-1:0]    data;
    } wr_req_t;

    function automatic logic [DW-1:0] lane_merge(
        input logic [DW-1:0]    old_v,
        input logic [DW-1:0]    new_v,
        input logic [LANES-1:0] be
    );
        logic [DW-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            r[i*8 +: 8] = be[i] ? new_v[i*8 +: 8] : old_v[i*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/ckrf_ctl.sv
module ckrf_ctl
    import ckrf_pkg::*;
(
    input  logic             commit_i,
    input  logic             rollback_i,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [LANES-1:0] wr_be,
    input  logic [DW-1:0]    wr_data,
    output ckpt_op_e         op,
    output wr_req_t          wreq
);

    // Restore has priority over capture; a restore cycle also drops the write.
    always_comb begin
        if (rollback_i)    op = OP_RESTORE;
        else if (commit_i) op = OP_CAPTURE;
        else               op = OP_IDLE;

        wreq.en   = wr_en & ~rollback_i;
        wreq.addr = wr_addr;
        wreq.be   = wr_be;
        wreq.data = wr_data;
    end

endmodule

// File: rtl/ckrf_cell.sv
module ckrf_cell
    import ckrf_pkg::*;
#(
    parameter int IDX        = 0,
    parameter bit HAS_SHADOW = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  ckpt_op_e      op,
    input  wr_req_t       wreq,
    output logic [DW-1:0] work_q
);

    logic          hit;
    logic [DW-1:0] work_nxt;

    assign hit      = wreq.en && (wreq.addr == AW'(IDX));
    assign work_nxt = hit ? lane_merge(work_q, wreq.data, wreq.be) : work_q;

    generate
        if (HAS_SHADOW) begin : g_shadowed
            logic [DW-1:0] shadow_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    work_q   <= '0;
                    shadow_q <= '0;
                end else begin
                    case (op)
                        OP_RESTORE: work_q <= shadow_q;
                        OP_CAPTURE: begin
                            work_q   <= work_nxt;
                            shadow_q <= work_nxt;
                        end
                        default:    work_q <= work_nxt;
                    endcase
                end
            end
        end else begin : g_scratch
            logic [1:0] unused_op;
            assign unused_op = op;

            always_ff @(posedge clk) begin
                if (rst) work_q <= '0;
                else     work_q <= work_nxt;
            end
        end
    endgenerate

endmodule

// File: rtl/ckrf_rdport.sv
module ckrf_rdport
    import ckrf_pkg::*;
(
    input  logic [NREGS-1:0][DW-1:0] work,
    input  wr_req_t                  wreq,
    input  logic [AW-1:0]            rd_addr,
    output logic [DW-1:0]            rd_data
);

    logic [DW-1:0] stored;

    assign stored  = work[rd_addr];
    assign rd_data = (wreq.en && wreq.addr == rd_addr)
                   ? lane_merge(stored, wreq.data, wreq.be)
                   : stored;

endmodule

// File: rtl/ckrf_top.sv
module ckrf_top
    import ckrf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [LANES-1:0] wr_be,
    input  logic [DW-1:0]    wr_data,
    input  logic             commit_i,
    input  logic             rollback_i,
    input  logic [AW-1:0]    rd0_addr,
    output logic [DW-1:0]    rd0_data,
    input  logic [AW-1:0]    rd1_addr,
    output logic [DW-1:0]    rd1_data
);

    ckpt_op_e                 op;
    wr_req_t                  wreq;
    logic [NREGS-1:0][DW-1:0] work;

    ckrf_ctl u_ctl (
        .commit_i   (commit_i),
        .rollback_i (rollback_i),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_be      (wr_be),
        .wr_data    (wr_data),
        .op         (op),
        .wreq       (wreq)
    );

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        ckrf_cell #(
            .IDX        (g),
            .HAS_SHADOW (g < NSHADOW)
        ) u_cell (
            .clk    (clk),
            .rst    (rst),
            .op     (op),
            .wreq   (wreq),
            .work_q (work[g])
        );
    end

    ckrf_rdport u_rd0 (
        .work    (work),
        .wreq    (wreq),
        .rd_addr (rd0_addr),
        .rd_data (rd0_data)
    );

    ckrf_rdport u_rd1 (
        .work    (work),
        .wreq    (wreq),
        .rd_addr (rd1_addr),
        .rd_data (rd1_data)
    );

endmodule

// File: rtl/ckrf_checker.sv
module ckrf_checker
    import ckrf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [LANES-1:0] wr_be,
    input logic [DW-1:0]    wr_data,
    input logic             commit_i,
    input logic             rollback_i,
    input logic [AW-1:0]    rd0_addr,
    input logic [DW-1:0]    rd0_data
);

    logic same_no_wr;
    assign same_no_wr = !(wr_en && !rollback_i && wr_addr == rd0_addr);

    // R9: a full-lane accepted write is visible on the read port in its own cycle
    p_bypass_full_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rollback_i && wr_be == '1 && rd0_addr == wr_addr)
            |-> rd0_data == wr_data);

    // R3: a write with no lanes enabled leaves the register unchanged
    p_no_lane_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rollback_i && wr_be == '0 && rd0_addr == wr_addr)
            |=> ((rd0_addr == $past(rd0_addr) && same_no_wr && !rollback_i)
                 ? rd0_data == $past(rd0_data) : 1'b1));

    // R6: scratch registers keep their value across a restore (R8: its write is dropped)
    p_scratch_restore_r6: assert property (@(posedge clk) disable iff (rst)
        (rollback_i && rd0_addr >= AW'(NSHADOW))
            |=> ((rd0_addr == $past(rd0_addr) && same_no_wr)
                 ? rd0_data == $past(rd0_data) : 1'b1));

    // R6: scratch registers keep their value across a capture when not written
    p_scratch_commit_r6: assert property (@(posedge clk) disable iff (rst)
        (commit_i && !rollback_i && rd0_addr >= AW'(NSHADOW) && same_no_wr)
            |=> ((rd0_addr == $past(rd0_addr) && same_no_wr)
                 ? rd0_data == $past(rd0_data) : 1'b1));

    // R8: a write in a restore cycle is not forwarded to a read of that register
    p_restore_no_fwd_r8: assert property (@(posedge clk) disable iff (rst)
        (rollback_i && wr_en && rd0_addr == wr_addr && rd0_addr >= AW'(NSHADOW))
            |=> ((rd0_addr == $past(rd0_addr) && same_no_wr)
                 ? rd0_data == $past(rd0_data) : 1'b1));

    logic unused_c;
    assign unused_c = commit_i;

endmodule

bind ckrf_top ckrf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_be      (wr_be),
    .wr_data    (wr_data),
    .commit_i   (commit_i),
    .rollback_i (rollback_i),
    .rd0_addr   (rd0_addr),
    .rd0_data   (rd0_data)
);

// File: tb/ckrf_top_tb.sv
module ckrf_top_tb;
    import ckrf_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [LANES-1:0] wr_be = '0;
    logic [DW-1:0]    wr_data = '0;
    logic             commit_i = 1'b0;
    logic             rollback_i = 1'b0;
    logic [AW-1:0]    rd0_addr = '0;
    logic [AW-1:0]    rd1_addr = '0;
    logic [DW-1:0]    rd0_data;
    logic [DW-1:0]    rd1_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] m_work [NREGS];
    logic [DW-1:0] m_shad [NREGS];

    always #4 clk = ~clk;   // 125 MHz

    ckrf_top u_dut (.*);

    function automatic logic [DW-1:0] mrg(logic [DW-1:0] o, logic [DW-1:0] n,
                                          logic [LANES-1:0] be);
        logic [DW-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*8 +: 8] = be[i] ? n[i*8 +: 8] : o[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [DW-1:0] exp_rd(logic [AW-1:0] a);
        if (wr_en && !rollback_i && wr_addr == a) return mrg(m_work[a], wr_data, wr_be);
        return m_work[a];
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check reads, then advance the model.
    task automatic step(bit we, int wa, logic [LANES-1:0] be, logic [DW-1:0] wd,
                        int ra0, int ra1, bit cm, bit rb, string tag);
        @(negedge clk);
        wr_en = we; wr_addr = AW'(wa); wr_be = be; wr_data = wd;
        rd0_addr = AW'(ra0); rd1_addr = AW'(ra1);
        commit_i = cm; rollback_i = rb;
        #1;
        check(tag, rd0_data, exp_rd(rd0_addr));
        check(tag, rd1_data, exp_rd(rd1_addr));
        @(posedge clk);
        if (rb) begin
            for (int i = 0; i < NSHADOW; i++) m_work[i] = m_shad[i];
        end else begin
            if (we) m_work[wa] = mrg(m_work[wa], wd, be);
            if (cm) for (int i = 0; i < NSHADOW; i++) m_shad[i] = m_work[i];
        end
    endtask

    task automatic idle_read(int a0, int a1, string tag);
        step(1'b0, 0, '0, '0, a0, a1, 1'b0, 1'b0, tag);
    endtask

    task automatic expect_reg(int a, logic [DW-1:0] v, string tag);
        @(negedge clk);
        wr_en = 1'b0; commit_i = 1'b0; rollback_i = 1'b0;
        rd0_addr = AW'(a);
        #1;
        check(tag, rd0_data, v);
    endtask

    initial begin
        for (int i = 0; i < NREGS; i++) begin m_work[i] = '0; m_shad[i] = '0; end
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: everything reads zero after reset, and a restore keeps it zero
        for (int i = 0; i < NREGS; i += 2) idle_read(i, i + 1, "R1 reset");
        step(1'b0, 0, '0, '0, 0, 63, 1'b0, 1'b1, "R1 restore");
        for (int i = 0; i < NREGS; i += 2) idle_read(i, i + 1, "R1 after restore");
        expect_reg(5, 32'h0, "R1 direct");

        // R3/R9: full then partial write with forwarding
        step(1'b1, 5, 4'hF, 32'h1122_3344, 5, 5, 1'b0, 1'b0, "R9 bypass full");
        step(1'b1, 5, 4'b0101, 32'hAABB_CCDD, 5, 0, 1'b0, 1'b0, "R9 bypass partial");
        expect_reg(5, 32'h11BB_33DD, "R3 lane merge");
        step(1'b1, 5, 4'b0000, 32'hFFFF_FFFF, 5, 5, 1'b0, 1'b0, "R3 no lanes");
        expect_reg(5, 32'h11BB_33DD, "R3 no lanes");

        // R4/R5/R6: checkpoint, then speculative writes, then restore
        step(1'b0, 0, '0, '0, 5, 50, 1'b1, 1'b0, "R4 commit");
        step(1'b1, 5, 4'hF, 32'hDEAD_BEEF, 5, 50, 1'b0, 1'b0, "R2 spec write");
        step(1'b1, 50, 4'hF, 32'h5050_5050, 50, 5, 1'b0, 1'b0, "R6 scratch write");
        step(1'b0, 0, '0, '0, 5, 50, 1'b0, 1'b1, "R5 restore");
        expect_reg(5, 32'h11BB_33DD, "R5 restored value");
        expect_reg(50, 32'h5050_5050, "R6 scratch kept");

        // R7: both pulses together, restore wins and backup stays old
        step(1'b1, 6, 4'hF, 32'h0000_0066, 6, 6, 1'b0, 1'b0, "R7 setup");
        step(1'b0, 0, '0, '0, 6, 5, 1'b1, 1'b1, "R7 both pulses");
        expect_reg(6, 32'h0, "R7 restore wins");
        step(1'b1, 6, 4'hF, 32'h0000_0077, 6, 6, 1'b0, 1'b0, "R7 rewrite");
        step(1'b0, 0, '0, '0, 6, 6, 1'b0, 1'b1, "R7 second restore");
        expect_reg(6, 32'h0, "R7 backup unchanged");

        // R8: writes during restore are dropped, shadowed and scratch alike
        step(1'b1, 60, 4'hF, 32'h6060_6060, 60, 60, 1'b0, 1'b1, "R8 scratch drop");
        expect_reg(60, 32'h0, "R8 scratch drop");
        step(1'b1, 7, 4'hF, 32'h7777_7777, 7, 7, 1'b0, 1'b1, "R8 shadowed drop");
        expect_reg(7, 32'h0, "R8 shadowed drop");

        // R4: write in the commit cycle is inside the checkpoint
        step(1'b1, 7, 4'b0011, 32'h0000_A5A5, 7, 7, 1'b1, 1'b0, "R4 commit with write");
        step(1'b1, 7, 4'hF, 32'h1234_5678, 7, 7, 1'b0, 1'b0, "R4 spec write");
        step(1'b0, 0, '0, '0, 7, 7, 1'b0, 1'b1, "R4 restore");
        expect_reg(7, 32'h0000_A5A5, "R4 same-cycle write captured");

        // Boundary registers 47 and 48
        step(1'b1, 47, 4'hF, 32'h4747_4747, 47, 48, 1'b0, 1'b0, "R5 edge write");
        step(1'b1, 48, 4'hF, 32'h4848_4848, 48, 47, 1'b0, 1'b0, "R6 edge write");
        step(1'b0, 0, '0, '0, 47, 48, 1'b0, 1'b1, "R5 edge restore");
        expect_reg(47, 32'h0, "R5 reg 47 restored");
        expect_reg(48, 32'h4848_4848, "R6 reg 48 kept");

        // Constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            bit we, cm, rb;
            int wa, a0, a1;
            logic [LANES-1:0] be;
            we = ($urandom % 4) != 0;
            wa = $urandom % NREGS;
            be = LANES'($urandom);
            if (($urandom % 8) == 0) be = '0;
            if (($urandom % 4) == 0) be = '1;
            cm = ($urandom % 12) == 0;
            rb = ($urandom % 16) == 0;
            a0 = (($urandom % 3) == 0) ? wa : int'($urandom % NREGS);
            a1 = (($urandom % 3) == 0) ? int'(wr_addr) : int'($urandom % NREGS);
            step(we, wa, be, $urandom, a0, a1, cm, rb, "R2 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule